// File: doc/BRIEF.md
# Byte-Serial Status Packet Sender

This block sits on the source side of a low-bandwidth status link. It hands a short packet to a central collector over an 8-bit byte-serial path. A one-cycle send command latches the whole packet while the block is idle. The packet holds a destination address, an optional sequence number or a compact sequence/flag byte, and zero to three payload bytes. The block then raises a request line. It keeps the address byte on the data lines until the collector acknowledges that byte. After that it streams the remaining bytes, one per clock.

Payload goes out least significant byte first, after the sequence byte. The collector can then drop the sequence number into the top byte of a 32-bit word. In compact mode the low bits of the sequence byte carry single-bit status flags, and the packet is only two bytes long. A busy output covers the whole transfer. Send commands that arrive while the block is busy are dropped.

Top module: `status_pkt_tx`

## Requirements
- R1: During and after a synchronous active-low reset, `rq` and `busy` are 0 and `ad` is 0x00.
- R2: A `send` sampled high while `busy` is 0 is accepted. On the next cycle `rq` and `busy` are 1 and `ad` equals the `dest_addr` sampled with `send`.
- R3: While `rq` is 1 and `ack` is 0, `rq` stays 1 and `ad` keeps the address byte. An `ack` while `rq` is 0 has no effect.
- R4: `rq` falls in the cycle after the edge at which `ack` is sampled high with `rq` high. One acknowledge therefore serves exactly one packet.
- R5: The bytes after the address go out on consecutive cycles, beginning the cycle after the acknowledge. With `seq_en`=1 the order is the sequence byte, then `pay_len` payload bytes, taking `payload[7:0]` first, then `payload[15:8]`, then `payload[23:16]`.
- R6: With `seq_en`=0 and `compact`=0, the payload bytes follow the address directly. With `pay_len`=0 the packet is the address byte alone.
- R7: With `compact`=1 the packet is exactly two bytes: the address, then `{seq_num[7:2], flags[1:0]}` (for FLAG_BITS=2). `seq_en` and `pay_len` are ignored.
- R8: `busy` is 1 from the cycle after an accepted `send` through the cycle that drives the last byte, and 0 in the cycle after that. A `send` while `busy` is 1 is ignored.
- R9: While `busy` is 0, `ad` is 0x00. A `send` sampled in the first cycle after a packet ends is accepted.
- R10: Reset asserted mid-packet abandons the packet: `rq` and `busy` drop and `ad` returns to 0x00 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| send | input | 1 | Send command, sampled when idle |
| dest_addr | input | 8 | Destination register address (first byte) |
| seq_num | input | 8 | Sequence number |
| seq_en | input | 1 | Include the sequence byte before the payload |
| compact | input | 1 | Two-byte packet with flags in the sequence byte |
| flags | input | FLAG_BITS (2) | Status flags for compact mode |
| payload | input | 8*MAX_PAY (24) | Payload bytes, byte 0 in bits 7:0 |
| pay_len | input | $clog2(MAX_PAY+1) (2) | Number of payload bytes, 0..MAX_PAY |
| ack | input | 1 | Collector has taken the address byte |
| rq | output | 1 | Transfer request |
| busy | output | 1 | Packet in progress |
| ad | output | 8 | Byte-serial data |

## Verification
The assertions assume that the collector treats `ack` as a reply to a visible `rq`. They also assume that every packet field is stable only at the edge where `send` is sampled, and that nothing is guaranteed between edges. The bench collector raises `ack` only after a chosen number of request cycles. It then clears `ack` once `rq` falls. In one deliberate phase it also pulses `ack` while no request is pending. The address-hold property is gated by `ack`, so this stray pulse stays within what it allows. Packet fields are changed freely while the block is busy, to show that only the accepted snapshot is sent.

// File: rtl/status_pkt_pkg.sv
// Shared types for the byte-serial status packet sender.
// Assumes an 8-bit serial data path.
package status_pkt_pkg;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_REQ    = 2'd1,
        TX_STREAM = 2'd2
    } tx_state_e;
endpackage

// File: rtl/status_pkt_assembler.sv
// Builds the ordered byte list and byte count of a packet from the command
// fields. Purely combinational; the sequencer latches the result on accept.
// Assumes 1 <= FLAG_BITS <= 7 and pay_len <= MAX_PAY.
module status_pkt_assembler
    import status_pkt_pkg::*;
#(
    parameter int MAX_PAY   = 3,
    parameter int FLAG_BITS = 2,
    localparam int MAX_BYTES = MAX_PAY + 2,
    localparam int LEN_W     = $clog2(MAX_PAY + 1),
    localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic [7:0]                      dest_addr,
    input  logic [7:0]                      seq_num,
    input  logic                            seq_en,
    input  logic                            compact,
    input  logic [FLAG_BITS-1:0]            flags,
    input  logic [8*MAX_PAY-1:0]            payload,
    input  logic [LEN_W-1:0]                pay_len,
    output logic [MAX_BYTES-1:0][BYTE_W-1:0] pkt_bytes,
    output logic [CNT_W-1:0]                pkt_cnt
);
    byte_t pay_b [MAX_PAY];
    byte_t packed_seq;

    // Split the flat payload into byte slots, byte 0 lowest.
    for (genvar i = 0; i < MAX_PAY; i++) begin : g_slot
        assign pay_b[i] = payload[8*i +: 8];
    end

    // Compact mode: flags replace the low bits of the sequence number.
    assign packed_seq = {seq_num[7:FLAG_BITS], flags};

    // Place bytes in transmit order and compute the packet length.
    always_comb begin
        pkt_bytes    = '0;
        pkt_bytes[0] = dest_addr;
        if (compact) begin
            pkt_bytes[1] = packed_seq;
            pkt_cnt      = CNT_W'(2);
        end else if (seq_en) begin
            pkt_bytes[1] = seq_num;
            for (int j = 0; j < MAX_PAY; j++) pkt_bytes[j+2] = pay_b[j];
            pkt_cnt = CNT_W'(2) + CNT_W'(pay_len);
        end else begin
            for (int j = 0; j < MAX_PAY; j++) pkt_bytes[j+1] = pay_b[j];
            pkt_cnt = CNT_W'(1) + CNT_W'(pay_len);
        end
    end
endmodule

// File: rtl/status_pkt_sequencer.sv
// Handshake and byte streaming. Latches a packet when idle, requests, holds
// the address until ack, then streams the remaining bytes one per clock.
// Assumes pkt_cnt >= 1 on accept. Synchronous active-low reset.
module status_pkt_sequencer
    import status_pkt_pkg::*;
#(
    parameter int MAX_BYTES = 5,
    localparam int CNT_W = $clog2(MAX_BYTES + 1),
    localparam int IDX_W = $clog2(MAX_BYTES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             send,
    input  logic [MAX_BYTES-1:0][BYTE_W-1:0] pkt_bytes,
    input  logic [CNT_W-1:0]                 pkt_cnt,
    input  logic                             ack,
    output logic                             rq,
    output logic                             busy,
    output logic [BYTE_W-1:0]                ad
);
    tx_state_e                      state_q;
    logic [MAX_BYTES-1:0][BYTE_W-1:0] pkt_q;
    logic [CNT_W-1:0]               cnt_q;
    logic [IDX_W-1:0]               idx_q;
    logic                           last_byte;

    assign last_byte = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;

    // Packet state: accept, wait for acknowledge, stream, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            pkt_q   <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                TX_IDLE: if (send) begin
                    pkt_q   <= pkt_bytes;
                    cnt_q   <= pkt_cnt;
                    idx_q   <= '0;
                    state_q <= TX_REQ;
                end
                TX_REQ: if (ack) begin
                    idx_q   <= IDX_W'(1);
                    state_q <= (cnt_q == CNT_W'(1)) ? TX_IDLE : TX_STREAM;
                end
                TX_STREAM: begin
                    if (last_byte) begin
                        idx_q   <= '0;
                        state_q <= TX_IDLE;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    assign rq   = (state_q == TX_REQ);
    assign busy = (state_q != TX_IDLE);

    // Data lines: address while requesting, current byte while streaming.
    always_comb begin
        case (state_q)
            TX_REQ:    ad = pkt_q[0];
            TX_STREAM: ad = pkt_q[idx_q];
            default:   ad = '0;
        endcase
    end

    p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rq && !ack) |=> (rq && $stable(ad)))
        else $error("address not held while waiting for ack");

    p_rq_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rq && ack) |=> !rq)
        else $error("request not dropped after ack");

    p_rq_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rq |-> busy)
        else $error("request without busy");

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ad == '0))
        else $error("data lines not zero while idle");
endmodule

// File: rtl/status_pkt_tx.sv
// Top of the byte-serial status packet sender: the assembler orders the
// bytes, the sequencer runs the request/acknowledge handshake and streaming.
// Assumes the collector answers a visible request with ack.
module status_pkt_tx
    import status_pkt_pkg::*;
#(
    parameter int MAX_PAY   = 3,
    parameter int FLAG_BITS = 2,
    localparam int LEN_W     = $clog2(MAX_PAY + 1),
    localparam int MAX_BYTES = MAX_PAY + 2,
    localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 send,
    input  logic [7:0]           dest_addr,
    input  logic [7:0]           seq_num,
    input  logic                 seq_en,
    input  logic                 compact,
    input  logic [FLAG_BITS-1:0] flags,
    input  logic [8*MAX_PAY-1:0] payload,
    input  logic [LEN_W-1:0]     pay_len,
    input  logic                 ack,
    output logic                 rq,
    output logic                 busy,
    output logic [7:0]           ad
);
    logic [MAX_BYTES-1:0][BYTE_W-1:0] pkt_bytes;
    logic [CNT_W-1:0]                 pkt_cnt;

    status_pkt_assembler #(
        .MAX_PAY   (MAX_PAY),
        .FLAG_BITS (FLAG_BITS)
    ) i_asm (
        .dest_addr (dest_addr),
        .seq_num   (seq_num),
        .seq_en    (seq_en),
        .compact   (compact),
        .flags     (flags),
        .payload   (payload),
        .pay_len   (pay_len),
        .pkt_bytes (pkt_bytes),
        .pkt_cnt   (pkt_cnt)
    );

    status_pkt_sequencer #(
        .MAX_BYTES (MAX_BYTES)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .send      (send),
        .pkt_bytes (pkt_bytes),
        .pkt_cnt   (pkt_cnt),
        .ack       (ack),
        .rq        (rq),
        .busy      (busy),
        .ad        (ad)
    );

    p_accept_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && send) |=> (rq && busy && ad == $past(dest_addr)))
        else $error("send not accepted with its address");

    p_start_needs_send_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(send))
        else $error("packet started without send");
endmodule

// File: tb/test_status_pkt_tx.sv
module test_status_pkt_tx;
    logic        clk = 1'b0;
    logic        rst_n, send, seq_en, compact, ack;
    logic [7:0]  dest_addr, seq_num;
    logic [1:0]  flags, pay_len;
    logic [23:0] payload;
    logic        rq, busy;
    logic [7:0]  ad;

    int vectors = 0, errors = 0, cycles = 0;
    int rq_cnt = 0, ack_dly = 0;
    bit stray = 1'b0;

    always #10 clk = ~clk;

    status_pkt_tx i_status_pkt_tx (
        .clk(clk), .rst_n(rst_n), .send(send), .dest_addr(dest_addr),
        .seq_num(seq_num), .seq_en(seq_en), .compact(compact), .flags(flags),
        .payload(payload), .pay_len(pay_len), .ack(ack),
        .rq(rq), .busy(busy), .ad(ad)
    );

    // Reference model: queue of bytes still to be shown on the data lines.
    logic [7:0] q[$];
    bit m_rq = 1'b0, m_busy = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_rq = 1'b0; m_busy = 1'b0;
        end else if (m_busy) begin
            if (m_rq) begin
                if (ack) begin m_rq = 1'b0; void'(q.pop_front()); end
            end else begin
                void'(q.pop_front());
            end
            if (q.size() == 0) m_busy = 1'b0;
        end else if (send) begin
            q.push_back(dest_addr);
            if (compact) q.push_back({seq_num[7:2], flags});
            else begin
                if (seq_en) q.push_back(seq_num);
                for (int k = 0; k < int'(pay_len); k++) q.push_back(payload[8*k +: 8]);
            end
            m_rq = 1'b1; m_busy = 1'b1;
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    // Compare all outputs against the model, then update the collector's ack.
    task automatic step(string tag);
        logic [7:0] exp_ad;
        @(negedge clk);
        exp_ad = m_busy ? q[0] : 8'h00;
        vectors++;
        if (rq !== m_rq) begin
            errors++;
            $display("FAIL %s rq: actual=%b expected=%b", tag, rq, m_rq);
        end
        if (busy !== m_busy) begin
            errors++;
            $display("FAIL %s busy: actual=%b expected=%b", tag, busy, m_busy);
        end
        if (ad !== exp_ad) begin
            errors++;
            $display("FAIL %s ad: actual=%h expected=%h", tag, ad, exp_ad);
        end
        if (rq) begin
            ack = (rq_cnt == ack_dly);
            rq_cnt++;
        end else begin
            rq_cnt = 0;
            ack = stray;
        end
    endtask

    task automatic send_pkt(string tag, logic [7:0] a, logic [7:0] s, logic [23:0] p,
                            logic [1:0] l, logic se, logic cm, logic [1:0] f, int dly);
        dest_addr = a; seq_num = s; payload = p; pay_len = l;
        seq_en = se; compact = cm; flags = f; ack_dly = dly;
        send = 1'b1;
        step(tag);
        send = 1'b0;
        for (int n = 0; n < 20 && (busy || rq); n++) step(tag);
        step(tag);
    endtask

    initial begin
        rst_n = 1'b0; send = 1'b0; seq_en = 1'b0; compact = 1'b0; ack = 1'b0;
        dest_addr = '0; seq_num = '0; flags = '0; pay_len = '0; payload = '0;
        repeat (3) step("R1");
        rst_n = 1'b1;
        step("R1");

        // R2/R5: sequence number plus three payload bytes, ack delayed.
        send_pkt("R5", 8'h3C, 8'h91, 24'hC2B1A0, 2'd3, 1'b1, 1'b0, 2'b00, 2);
        // R5: sequence byte and one payload byte, immediate ack.
        send_pkt("R5", 8'h11, 8'h07, 24'h0000EE, 2'd1, 1'b1, 1'b0, 2'b00, 0);
        // R6: no sequence, two payload bytes; then address-only packet.
        send_pkt("R6", 8'h40, 8'hFF, 24'h00BEEF, 2'd2, 1'b0, 1'b0, 2'b00, 1);
        send_pkt("R6", 8'h5A, 8'hFF, 24'h123456, 2'd0, 1'b0, 1'b0, 2'b00, 3);
        // R7: compact packet ignores seq_en and pay_len.
        send_pkt("R7", 8'h22, 8'hA5, 24'h999999, 2'd3, 1'b0, 1'b1, 2'b10, 1);
        send_pkt("R7", 8'h23, 8'h5F, 24'h999999, 2'd2, 1'b1, 1'b1, 2'b01, 0);

        // R3: stray acks while idle and while waiting, long ack delay.
        stray = 1'b1;
        repeat (4) step("R3");
        send_pkt("R3", 8'h77, 8'h01, 24'h000042, 2'd1, 1'b1, 1'b0, 2'b00, 4);
        stray = 1'b0;
        step("R4");

        // R8/R9: send held high with changing fields; busy drops them,
        // the first idle cycle accepts the next one.
        ack_dly = 1; seq_en = 1'b1; compact = 1'b0; pay_len = 2'd2; send = 1'b1;
        for (int c = 0; c < 24; c++) begin
            dest_addr = 8'(c * 7 + 1); seq_num = 8'(c); payload = 24'(c * 131071);
            step("R8");
        end
        send = 1'b0;
        repeat (8) step("R9");

        // R10: reset during streaming abandons the packet.
        dest_addr = 8'h61; seq_num = 8'h62; payload = 24'h656463; pay_len = 2'd3;
        seq_en = 1'b1; ack_dly = 0; send = 1'b1;
        step("R10");
        send = 1'b0;
        repeat (2) step("R10");
        rst_n = 1'b0;
        step("R10");
        rst_n = 1'b1;
        repeat (3) step("R10");

        // R4/R5: random packets with random ack delays.
        for (int r = 0; r < 300; r++) begin
            send_pkt("R4", 8'($urandom), 8'($urandom), 24'($urandom), 2'($urandom),
                     1'($urandom), (($urandom % 5) == 0), 2'($urandom), int'($urandom % 4));
        end
        finish_run();
    end
endmodule